// File: doc/BRIEF.md
# Subroutine Stack Controller

This block keeps a stack in the same single-port memory that a small processor uses for its program and its video data. It holds the stack pointer and carries out five stack operations on behalf of the instruction decoder: setting the pointer, pushing a value, popping a value into a register, calling a subroutine, and returning from one. For every operation it drives the memory address, write data and write strobe. It reads memory through an asynchronous read port, so read data comes back in the same cycle.

A call saves the address of the instruction that follows it and redirects the program counter to the target. A return starts by popping an argument count and throwing away that many entries. It then pops the saved return address into the program counter. A return takes two cycles. During its second cycle the block raises `busy` so that fetch stalls, and it ignores any operation presented in that cycle. Every other operation takes one cycle. The stack grows upward: a push writes at the pointer and then increments it, and a pop decrements the pointer and then reads.

Top module: `stack_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, `sp` is 0, and `busy`, `mem_we`, `pc_load` and `pop_valid` are all 0.
- R2: `op_code` 1 (set pointer) loads `sp` with the low ADDR_W bits of `op_arg` at the next edge and drives no memory write.
- R3: `op_code` 2 (push) with `imm_sel` low writes `push_reg` at address `sp` in the same cycle, and `sp` rises by one.
- R4: A push with `imm_sel` high writes `push_imm`, zero-extended to DATA_W, in place of `push_reg`.
- R5: `op_code` 3 (pop) reads address `sp-1`. In that cycle it presents the word on `pop_data` with `pop_valid` high, and `sp` falls by one.
- R6: `op_code` 4 (call) writes `pc_in+1` at address `sp` and increments `sp`. In the same cycle it raises `pc_load` with `pc_next` equal to `op_arg`.
- R7: `op_code` 5 (return), first cycle: the block reads a count N from address `sp-1`, taking the low ADDR_W bits. `sp` becomes `sp-1-N`, `busy` is low in this cycle and `busy` is high in the next cycle.
- R8: In the second return cycle the block reads address `sp-1` and raises `pc_load` with `pc_next` equal to that word, and `sp` falls by one. `busy` is high for this one cycle only, and no memory write occurs. The operation inputs in this cycle have no effect.
- R9: All pointer arithmetic wraps modulo 2^ADDR_W. A push at the top address leaves `sp` at 0, and a pop from 0 reads the top address.
- R10: `op_code` 0 and the unused codes 6 and 7 write nothing, load nothing and leave `sp` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Operation: 0 none, 1 set pointer, 2 push, 3 pop, 4 call, 5 return |
| op_arg | input | DATA_W | Pointer value for set pointer, target address for call |
| push_reg | input | DATA_W | Register value to push |
| push_imm | input | IMM_W | Immediate value to push |
| imm_sel | input | 1 | Push the immediate instead of the register |
| pc_in | input | DATA_W | Program counter of the current instruction |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | DATA_W | Memory read data, valid in the same cycle |
| pop_data | output | DATA_W | Popped word for the destination register |
| pop_valid | output | 1 | `pop_data` is valid this cycle |
| pc_load | output | 1 | Load `pc_next` into the program counter |
| pc_next | output | DATA_W | New program counter value |
| busy | output | 1 | Second return cycle; fetch must stall |
| sp | output | ADDR_W | Stack pointer |

## Verification
The bench builds the block with ADDR_W=8, DATA_W=16 and IMM_W=8. The 8-bit pointer lets a bench memory of 256 words hold the whole address space. It also brings the wrap from the top address to zero within reach for pushes, calls and a return that straddles the boundary. With a 16-bit data word, a saved return address can have bits above the pointer width, and the zero-extension of the 8-bit immediate is visible at the memory port.

// File: rtl/stkc_pkg.sv
package stkc_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_SETP = 3'd1,
    OP_PUSH = 3'd2,
    OP_POP  = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5
  } stk_op_e;
endpackage

// File: rtl/stkc_decode.sv
module stkc_decode
  import stkc_pkg::*;
(
  input  logic [2:0] op_code,
  input  logic       busy,
  output logic       setp_go,
  output logic       push_go,
  output logic       pop_go,
  output logic       call_go,
  output logic       ret_go
);
  logic free;
  assign free    = !busy;
  assign setp_go = free && (op_code == OP_SETP);
  assign push_go = free && (op_code == OP_PUSH);
  assign pop_go  = free && (op_code == OP_POP);
  assign call_go = free && (op_code == OP_CALL);
  assign ret_go  = free && (op_code == OP_RET);
endmodule

// File: rtl/stkc_ptr.sv
module stkc_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              up,
  input  logic              down,
  input  logic              unwind,
  input  logic [ADDR_W-1:0] unwind_n,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] sp_below
);
  function automatic logic [ADDR_W-1:0] ptr_up(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] ptr_down(input logic [ADDR_W-1:0] p);
    return p - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] ptr_unwind(input logic [ADDR_W-1:0] p,
                                                   input logic [ADDR_W-1:0] n);
    return p - ADDR_W'(1) - n;
  endfunction

  logic [ADDR_W-1:0] sp_d;

  assign sp_below = ptr_down(sp);

  always_comb begin
    sp_d = sp;
    if (load)        sp_d = load_val;
    else if (up)     sp_d = ptr_up(sp);
    else if (down)   sp_d = ptr_down(sp);
    else if (unwind) sp_d = ptr_unwind(sp, unwind_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sp <= '0;
    else        sp <= sp_d;
  end
endmodule

// File: rtl/stkc_ret_seq.sv
module stkc_ret_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic ret_go,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= ret_go;
  end
endmodule

// File: rtl/stkc_port.sv
module stkc_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              push_go,
  input  logic              call_go,
  input  logic              read_go,
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] push_reg,
  input  logic [IMM_W-1:0]  push_imm,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp,
  input  logic [ADDR_W-1:0] sp_below,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we
);
  function automatic logic [DATA_W-1:0] link_of(input logic [DATA_W-1:0] pc);
    return pc + DATA_W'(1);
  endfunction

  logic [DATA_W-1:0] push_val;

  assign push_val  = imm_sel ? DATA_W'(push_imm) : push_reg;
  assign mem_we    = push_go || call_go;
  assign mem_wdata = call_go ? link_of(pc_in) : push_val;
  assign mem_addr  = read_go ? sp_below : sp;
endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] op_arg,
  input  logic [DATA_W-1:0] push_reg,
  input  logic [IMM_W-1:0]  push_imm,
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] pc_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_valid,
  output logic              pc_load,
  output logic [DATA_W-1:0] pc_next,
  output logic              busy,
  output logic [ADDR_W-1:0] sp
);
  logic setp_go, push_go, pop_go, call_go, ret_go;
  logic read_go;
  logic [ADDR_W-1:0] sp_below;
  logic [ADDR_W-1:0] drop_n;

  stkc_decode u_dec (
    .op_code (op_code),
    .busy    (busy),
    .setp_go (setp_go),
    .push_go (push_go),
    .pop_go  (pop_go),
    .call_go (call_go),
    .ret_go  (ret_go)
  );

  stkc_ret_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .ret_go (ret_go),
    .busy   (busy)
  );

  assign drop_n  = mem_rdata[ADDR_W-1:0];
  assign read_go = pop_go || ret_go || busy;

  stkc_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (setp_go),
    .load_val (op_arg[ADDR_W-1:0]),
    .up       (push_go || call_go),
    .down     (pop_go || busy),
    .unwind   (ret_go),
    .unwind_n (drop_n),
    .sp       (sp),
    .sp_below (sp_below)
  );

  stkc_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W)) u_port (
    .push_go   (push_go),
    .call_go   (call_go),
    .read_go   (read_go),
    .imm_sel   (imm_sel),
    .push_reg  (push_reg),
    .push_imm  (push_imm),
    .pc_in     (pc_in),
    .sp        (sp),
    .sp_below  (sp_below),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we)
  );

  assign pop_data  = mem_rdata;
  assign pop_valid = pop_go;
  assign pc_load   = call_go || busy;
  assign pc_next   = call_go ? op_arg : mem_rdata;
endmodule

// File: rtl/stack_ctrl_chk.sv
module stack_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] op_arg,
  input logic [DATA_W-1:0] pc_in,
  input logic [ADDR_W-1:0] sp,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              pc_load,
  input logic              pop_valid,
  input logic              setp_go,
  input logic              push_go,
  input logic              pop_go,
  input logic              call_go,
  input logic              ret_go
);
  a_r2_setp_loads: assert property (@(posedge clk) disable iff (!rst_n)
    setp_go |=> sp == $past(op_arg[ADDR_W-1:0]));

  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    push_go |=> sp == $past(sp) + ADDR_W'(1));

  a_r5_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    pop_go |=> sp == $past(sp) - ADDR_W'(1));

  a_r6_call_link: assert property (@(posedge clk) disable iff (!rst_n)
    call_go |-> mem_we && mem_addr == sp && mem_wdata == pc_in + DATA_W'(1));

  a_r7_ret_unwind: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go |=> busy && sp == $past(sp) - ADDR_W'(1) - $past(mem_rdata[ADDR_W-1:0]));

  a_r8_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r8_busy_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_we && pc_load && !pop_valid);

  a_r10_load_source: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (call_go || busy));
endmodule

bind stack_ctrl stack_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/stack_ctrl_test.sv
module stack_ctrl_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [2:0]    op_code = '0;
  logic [DW-1:0] op_arg = '0;
  logic [DW-1:0] push_reg = '0;
  logic [IW-1:0] push_imm = '0;
  logic          imm_sel = 1'b0;
  logic [DW-1:0] pc_in = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] pop_data;
  logic          pop_valid;
  logic          pc_load;
  logic [DW-1:0] pc_next;
  logic          busy;
  logic [AW-1:0] sp;

  stack_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IMM_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_arg(op_arg),
    .push_reg(push_reg), .push_imm(push_imm), .imm_sel(imm_sel), .pc_in(pc_in),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .pop_data(pop_data), .pop_valid(pop_valid),
    .pc_load(pc_load), .pc_next(pc_next), .busy(busy), .sp(sp)
  );

  logic [DW-1:0] mem [0:(1<<AW)-1];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  logic [DW:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard driver side: expected popped words (bit DW=0) and PC loads (bit DW=1)
  task automatic expect_item(input bit is_pc, input logic [DW-1:0] v, input string tag);
    exp_q.push_back({is_pc, v});
    tag_q.push_back(tag);
  endtask

  // monitor: samples 5 ns after the falling edge
  always @(negedge clk) begin
    #5;
    if (rst_n && (pop_valid || pc_load)) begin
      logic [DW:0] got;
      got = pc_load ? {1'b1, pc_next} : {1'b0, pop_data};
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected result", 32'(got), 32'hFFFF_FFFF);
      end else begin
        logic [DW:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, 32'(got), 32'(e));
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [DW-1:0] arg,
                       input logic [DW-1:0] rv, input logic [IW-1:0] iv,
                       input bit sel, input logic [DW-1:0] pc);
    @(negedge clk);
    op_code = op; op_arg = arg; push_reg = rv; push_imm = iv; imm_sel = sel; pc_in = pc;
  endtask

  task automatic idle_sp(input logic [AW-1:0] e, input string tag);
    @(negedge clk);
    op_code = 3'd0;
    #5 chk(sp == e, tag, 32'(sp), 32'(e));
  endtask

  task automatic do_ret(input logic [2:0] other_op, input logic [DW-1:0] other_val);
    issue(3'd5, '0, '0, '0, 1'b0, '0);
    #5 chk(busy == 1'b0, "R7 busy low in first return cycle", 32'(busy), 0);
    issue(other_op, other_val, other_val, '0, 1'b0, '0);
    #5 chk(busy == 1'b1, "R8 busy in second return cycle", 32'(busy), 1);
    chk(mem_we == 1'b0, "R8 no write in second return cycle", 32'(mem_we), 0);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    #5;
    chk(sp == 0 && busy == 0 && mem_we == 0 && pc_load == 0 && pop_valid == 0,
        "R1 reset state", {sp, 3'b0, busy, mem_we, pc_load, pop_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    #5 chk(sp == 0 && busy == 0, "R1 first cycle after reset", 32'(sp), 0);

    issue(3'd1, 16'h0010, '0, '0, 1'b0, '0);
    #5 chk(mem_we == 0, "R2 no write on set pointer", 32'(mem_we), 0);
    idle_sp(8'h10, "R2 pointer loaded");

    issue(3'd2, '0, 16'hABCD, 8'h00, 1'b0, '0);
    idle_sp(8'h11, "R3 push increments");
    chk(mem[8'h10] == 16'hABCD, "R3 register pushed", 32'(mem[8'h10]), 32'hABCD);

    issue(3'd2, '0, 16'hFFFF, 8'h5A, 1'b1, '0);
    idle_sp(8'h12, "R4 immediate push increments");
    chk(mem[8'h11] == 16'h005A, "R4 immediate zero-extended", 32'(mem[8'h11]), 32'h005A);

    expect_item(1'b0, 16'h005A, "R5 pop newest");
    issue(3'd3, '0, '0, '0, 1'b0, '0);
    expect_item(1'b0, 16'hABCD, "R5 pop older");
    issue(3'd3, '0, '0, '0, 1'b0, '0);
    idle_sp(8'h10, "R5 pops decrement");

    expect_item(1'b1, 16'h0300, "R6 call target");
    issue(3'd4, 16'h0300, '0, '0, 1'b0, 16'h0042);
    idle_sp(8'h11, "R6 call increments");
    chk(mem[8'h10] == 16'h0043, "R6 link saved", 32'(mem[8'h10]), 32'h0043);

    issue(3'd2, '0, 16'h1111, '0, 1'b0, '0);
    issue(3'd2, '0, 16'h2222, '0, 1'b0, '0);
    issue(3'd2, '0, '0, 8'h02, 1'b1, '0);
    idle_sp(8'h14, "R3 arguments pushed");

    expect_item(1'b1, 16'h0043, "R8 return address");
    do_ret(3'd2, 16'hEEEE);
    idle_sp(8'h10, "R7 count discarded");
    chk(mem[8'h11] == 16'h1111, "R8 push during busy ignored", 32'(mem[8'h11]), 32'h1111);

    issue(3'd1, 16'h00FF, '0, '0, 1'b0, '0);
    issue(3'd2, '0, 16'h7777, '0, 1'b0, '0);
    idle_sp(8'h00, "R9 push wraps to zero");
    chk(mem[8'hFF] == 16'h7777, "R9 top address written", 32'(mem[8'hFF]), 32'h7777);
    expect_item(1'b0, 16'h7777, "R9 pop from zero");
    issue(3'd3, '0, '0, '0, 1'b0, '0);
    idle_sp(8'hFF, "R9 pop wraps to top");

    expect_item(1'b1, 16'h0010, "R6 call across top");
    issue(3'd4, 16'h0010, '0, '0, 1'b0, 16'h00FF);
    issue(3'd2, '0, '0, 8'h00, 1'b1, '0);
    idle_sp(8'h01, "R9 call and push wrap");
    expect_item(1'b1, 16'h0100, "R8 wide return address");
    do_ret(3'd1, 16'h0033);
    idle_sp(8'hFF, "R7 zero count return across wrap");

    issue(3'd7, 16'h0055, 16'h0055, 8'h55, 1'b0, '0);
    #5 chk(mem_we == 0 && pc_load == 0 && pop_valid == 0, "R10 code 7 no action",
           {mem_we, pc_load, pop_valid}, 0);
    issue(3'd6, 16'h0055, 16'h0055, 8'h55, 1'b1, '0);
    #5 chk(mem_we == 0 && pc_load == 0 && pop_valid == 0, "R10 code 6 no action",
           {mem_we, pc_load, pop_valid}, 0);
    issue(3'd0, 16'h0055, '0, '0, 1'b0, '0);
    idle_sp(8'hFF, "R10 pointer unchanged");

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all expected results seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule